// File: doc/BRIEF.md
# Pin Bank with Per-Pin Interrupt Sensing

This block drives and observes a bank of 32 general-purpose pins. Software reaches it through a plain register port: an address, a write strobe, write data and read data that is valid in the same cycle. One register holds the output values and another chooses which pins drive. The block produces a tri-state enable and an output value for every pin. Pin inputs pass through a synchroniser before any logic uses them.

Every pin can raise an interrupt. Three type registers, read together at the same bit position, select how the pin is sensed: rising edge, falling edge, either edge, high level or low level. When a pin's event occurs and its enable bit is set, a sticky status bit is set. Software clears that bit by writing 1 to it. All pending enabled status bits are ORed onto a single interrupt line for the bank.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq` is low.
- R2: `pin_oe` equals the direction register at offset 0x04 (1 = the pin drives). `pin_out` equals the output latch written at offset 0x00. Both change on the clock edge after the write.
- R3: A read of offset 0x00 returns the output latch bit for pins whose direction bit is 1 and the synchronised input for pins whose direction bit is 0. A pin change is visible two clock edges after it occurs.
- R4: The type bits (type2 at 0x14, type1 at 0x10, type0 at 0x0C) select edge sensing when type1 is 0. In that case type0=1 with type2=0 means rising, type0=1 with type2=1 means either edge, and type0=0 means falling, whatever type2 holds. An edge is judged between consecutive synchronised samples.
- R5: With type1=1, type0=1 selects high-level sensing and type0=0 selects low-level sensing. The status bit is set again on every cycle the level stays active, so a clear does not last while the level persists.
- R6: Writing 1 to a bit of the status register (0x18) clears it. Writing 0 leaves it unchanged. Status bits never clear by themselves.
- R7: A pin whose enable bit (0x08) is 0 never sets its status bit. `irq` is high exactly when some status bit is 1 while its enable bit is 1.
- R8: If a clear and a new event hit the same status bit in the same cycle, the bit stays set.
- R9: The type and enable registers read back what was written. A read of an unmapped offset returns 0, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| pin_in | input | 32 | Raw pin inputs (asynchronous) |
| pin_out | output | 32 | Output values to the pins |
| pin_oe | output | 32 | Drive enables to the pins |
| irq | output | 1 | Bank interrupt |

## Verification
The assertions check on every cycle that the status bits stay sticky, that a write of 1 clears them, that an event beats a clear, that masked pins never become pending, that a quiet bank keeps the interrupt low and that the drive enables follow direction writes. Which sense mode catches which pin pattern, the two-edge sync delay on reads, the re-arming of level interrupts after a clear and the handling of unmapped offsets depend on sequences of stimulus. Only the bench scenarios show these, with its reference model compared on every clock and hand-computed spot values.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_DIR   = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h08;
  localparam logic [7:0] OFS_TYP0  = 8'h0C;
  localparam logic [7:0] OFS_TYP1  = 8'h10;
  localparam logic [7:0] OFS_TYP2  = 8'h14;
  localparam logic [7:0] OFS_ISTAT = 8'h18;

  typedef enum logic [2:0] {
    SNS_FALL,
    SNS_RISE,
    SNS_BOTH,
    SNS_HIGH,
    SNS_LOW
  } sense_e;

  // type1 picks level versus edge; type0 picks polarity; type2 widens a
  // rising edge to both edges.
  function automatic sense_e sense_decode(input logic t2, input logic t1,
                                          input logic t0);
    sense_e m;
    if (t1)       m = t0 ? SNS_HIGH : SNS_LOW;
    else if (!t0) m = SNS_FALL;
    else          m = t2 ? SNS_BOTH : SNS_RISE;
    return m;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= '0;
    end else begin
      stage_q[0] <= raw;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign cur  = stage_q[STAGES-1];
  assign prev = prev_q;

endmodule

// File: rtl/gpio_sense_cell.sv
module gpio_sense_cell
  import gpio_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic prev,
  input  logic en,
  input  logic t0,
  input  logic t1,
  input  logic t2,
  input  logic clr,
  output logic evt,
  output logic status
);

  logic hit;
  logic status_d, status_q;

  always_comb begin
    unique case (sense_decode(t2, t1, t0))
      SNS_RISE: hit = cur & ~prev;
      SNS_FALL: hit = ~cur & prev;
      SNS_BOTH: hit = cur ^ prev;
      SNS_HIGH: hit = cur;
      SNS_LOW:  hit = ~cur;
      default:  hit = 1'b0;
    endcase
    evt      = en & hit;
    // a fresh event outranks a clear in the same cycle
    status_d = (status_q & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign status = status_q;

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_TYP0  = ADDR_W'(OFS_TYP0);
  localparam logic [ADDR_W-1:0] A_TYP1  = ADDR_W'(OFS_TYP1);
  localparam logic [ADDR_W-1:0] A_TYP2  = ADDR_W'(OFS_TYP2);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT);

  logic [NPINS-1:0] wval;
  logic [NPINS-1:0] out_q, dir_q, en_q, t0_q, t1_q, t2_q;
  logic [NPINS-1:0] out_d, dir_d, en_d, t0_d, t1_d, t2_d;
  logic             wr_out, wr_dir, wr_en, wr_t0, wr_t1, wr_t2, wr_stat;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] pin_cur, pin_prev;
  logic [NPINS-1:0] irq_event, irq_status;

  assign wval = reg_wdata[NPINS-1:0];

  // write strobes per register
  always_comb begin
    wr_out  = reg_we && (reg_addr == A_DATA);
    wr_dir  = reg_we && (reg_addr == A_DIR);
    wr_en   = reg_we && (reg_addr == A_IEN);
    wr_t0   = reg_we && (reg_addr == A_TYP0);
    wr_t1   = reg_we && (reg_addr == A_TYP1);
    wr_t2   = reg_we && (reg_addr == A_TYP2);
    wr_stat = reg_we && (reg_addr == A_ISTAT);
    clr_mask = wr_stat ? wval : '0;
  end

  // next-state values
  always_comb begin
    out_d = wr_out ? wval : out_q;
    dir_d = wr_dir ? wval : dir_q;
    en_d  = wr_en  ? wval : en_q;
    t0_d  = wr_t0  ? wval : t0_q;
    t1_d  = wr_t1  ? wval : t1_q;
    t2_d  = wr_t2  ? wval : t2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      en_q  <= '0;
      t0_q  <= '0;
      t1_q  <= '0;
      t2_q  <= '0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
      en_q  <= en_d;
      t0_q  <= t0_d;
      t1_q  <= t1_d;
      t2_q  <= t2_d;
    end
  end

  gpio_in_sync #(
    .W      (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (pin_in),
    .cur   (pin_cur),
    .prev  (pin_prev)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_sense_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur    (pin_cur[i]),
      .prev   (pin_prev[i]),
      .en     (en_q[i]),
      .t0     (t0_q[i]),
      .t1     (t1_q[i]),
      .t2     (t2_q[i]),
      .clr    (clr_mask[i]),
      .evt    (irq_event[i]),
      .status (irq_status[i])
    );
  end

  // read mux, same-cycle
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_DATA:  reg_rdata[NPINS-1:0] = (dir_q & out_q) | (~dir_q & pin_cur);
      A_DIR:   reg_rdata[NPINS-1:0] = dir_q;
      A_IEN:   reg_rdata[NPINS-1:0] = en_q;
      A_TYP0:  reg_rdata[NPINS-1:0] = t0_q;
      A_TYP1:  reg_rdata[NPINS-1:0] = t1_q;
      A_TYP2:  reg_rdata[NPINS-1:0] = t2_q;
      A_ISTAT: reg_rdata[NPINS-1:0] = irq_status;
      default: reg_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(irq_status & en_q);

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  irq_status,
  input logic [NPINS-1:0]  irq_event,
  input logic [NPINS-1:0]  irq_en
);

  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT);

  logic [NPINS-1:0] clr_seen;
  assign clr_seen = (reg_we && reg_addr == A_ISTAT) ? reg_wdata[NPINS-1:0] : '0;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_DIR) |=> (pin_oe == $past(reg_wdata[NPINS-1:0])));

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(irq_status) & ~$past(clr_seen) & ~irq_status) == '0));

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irq_status & $past(clr_seen) & ~$past(irq_event)) == '0));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irq_status & ~$past(irq_status) & ~$past(irq_en)) == '0));

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status == '0) |-> !irq);

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((irq_status & $past(irq_event)) == $past(irq_event)));

endmodule

bind gpio_bank_irq gpio_bank_chk #(
  .NPINS  (NPINS),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_we     (reg_we),
  .reg_wdata  (reg_wdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .irq        (irq),
  .irq_status (irq_status),
  .irq_event  (irq_event),
  .irq_en     (en_q)
);

// File: tb/sim_gpio_bank_irq.sv
module sim_gpio_bank_irq;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R1";

  gpio_bank_irq u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [31:0] m_data, m_dir, m_en, m_t0, m_t1, m_t2, m_st;
  logic [31:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_en = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0; m_st = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] ev;
      logic [31:0] clr;
      ev = 0;
      for (int i = 0; i < 32; i++) begin
        bit s, p, e;
        s = hist[1][i];
        p = hist[0][i];
        if (!m_en[i])      e = 0;
        else if (m_t1[i])  e = m_t0[i] ? s : !s;
        else if (m_t0[i])  e = m_t2[i] ? (s != p) : (s && !p);
        else               e = (!s && p);
        ev[i] = e;
      end
      clr = (reg_we && reg_addr == 8'h18) ? reg_wdata : 32'h0;
      m_st = (m_st & ~clr) | ev;
      if (reg_we) begin
        case (reg_addr)
          8'h00: m_data = reg_wdata;
          8'h04: m_dir  = reg_wdata;
          8'h08: m_en   = reg_wdata;
          8'h0C: m_t0   = reg_wdata;
          8'h10: m_t1   = reg_wdata;
          8'h14: m_t2   = reg_wdata;
          default: ;
        endcase
      end
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return (m_dir & m_data) | (~m_dir & hist[1]);
      8'h04: return m_dir;
      8'h08: return m_en;
      8'h0C: return m_t0;
      8'h10: return m_t1;
      8'h14: return m_t2;
      8'h18: return m_st;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // per-clock comparison, a quarter period after the driving edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      check(cur_req, "rdata", reg_rdata, model_read(reg_addr));
      check("R2", "pin_oe", pin_oe, m_dir);
      check("R2", "pin_out", pin_out, m_data);
      check("R7", "irq", {31'h0, irq}, {31'h0, |(m_st & m_en)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reg_we = 1'b0;
    end
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b0; pin_in = v;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a,
                           input logic [31:0] exp);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #(CLK_P/4);
    check(req, $sformatf("read %02h", a), reg_rdata, exp);
  endtask

  task automatic expect_irq(input string req, input logic exp);
    #(CLK_P/4);
    check(req, "irq line", {31'h0, irq}, {31'h0, exp});
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h00; reg_wdata = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    expect_rd("R1", 8'h00, 32'h0);
    expect_rd("R1", 8'h04, 32'h0);
    expect_rd("R1", 8'h18, 32'h0);
    check("R1", "pin_oe", pin_oe, 32'h0);
    expect_irq("R1", 1'b0);

    // R2 R3 direction and mixed data read
    cur_req = "R3";
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h00, 32'h1234_5678);
    pins(32'hABCD_0000);
    idle(3);
    check("R2", "pin_oe", pin_oe, 32'h0000_FFFF);
    check("R2", "pin_out", pin_out, 32'h1234_5678);
    expect_rd("R3", 8'h00, 32'hABCD_5678);
    pins(32'h0);
    wr(8'h04, 32'h0);
    idle(3);
    expect_rd("R3", 8'h00, 32'h0);

    // R9 unmapped offset
    cur_req = "R9";
    wr(8'h40, 32'hFFFF_FFFF);
    expect_rd("R9", 8'h40, 32'h0);
    expect_rd("R9", 8'h04, 32'h0);

    // R4 edge modes: 16 rise, 17 fall, 18 both, 22 type2 only -> fall
    cur_req = "R4";
    wr(8'h08, 32'h0047_0000);
    wr(8'h0C, 32'h0005_0000);
    wr(8'h14, 32'h0044_0000);
    expect_rd("R9", 8'h14, 32'h0044_0000);
    pins(32'h0047_0000);
    idle(4);
    expect_rd("R4", 8'h18, 32'h0005_0000);
    expect_irq("R4", 1'b1);

    // R6 write 0 keeps, write 1 clears
    cur_req = "R6";
    wr(8'h18, 32'h0);
    expect_rd("R6", 8'h18, 32'h0005_0000);
    wr(8'h18, 32'h0005_0000);
    expect_rd("R6", 8'h18, 32'h0);
    expect_irq("R6", 1'b0);

    cur_req = "R4";
    pins(32'h0);
    idle(4);
    expect_rd("R4", 8'h18, 32'h0046_0000);
    wr(8'h18, 32'h0046_0000);
    expect_rd("R6", 8'h18, 32'h0);

    // R7 masked pin 21 never becomes pending
    cur_req = "R7";
    wr(8'h0C, 32'h0025_0000);
    pins(32'h0020_0000);
    idle(4);
    expect_rd("R7", 8'h18, 32'h0);
    expect_irq("R7", 1'b0);
    wr(8'h08, 32'h0067_0000);
    idle(4);
    expect_rd("R7", 8'h18, 32'h0);

    // R5 levels: 19 high, 20 low
    cur_req = "R5";
    wr(8'h0C, 32'h002D_0000);
    wr(8'h10, 32'h0018_0000);
    wr(8'h08, 32'h0018_0000);
    idle(4);
    expect_rd("R5", 8'h18, 32'h0010_0000);
    wr(8'h18, 32'h0010_0000);
    idle(2);
    expect_rd("R5", 8'h18, 32'h0010_0000);

    // R8 clear while level 19 is held: stays set; 20 goes inactive
    cur_req = "R8";
    pins(32'h0038_0000);
    idle(4);
    wr(8'h18, 32'h0018_0000);
    idle(2);
    expect_rd("R8", 8'h18, 32'h0008_0000);
    expect_irq("R8", 1'b1);

    cur_req = "R5";
    pins(32'h0030_0000);
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);
    idle(2);
    expect_rd("R5", 8'h18, 32'h0);
    expect_rd("R9", 8'h10, 32'h0018_0000);

    idle(2);
    finish_run();
  end

endmodule